// File: doc/BRIEF.md
# Slice register group

A bank of eight single-bit storage elements that share one control set: one clock, one active-high set/reset and one active-high clock enable. Each element has its own data input and output. Elements 0 to 3 are always edge-triggered flip-flops. Elements 4 to 7 are built as a group, either as flip-flops or as level-sensitive latches. A static parameter picks the choice for the whole group.

Static parameters also choose three more things. They pick the clock polarity. They pick whether set/reset acts synchronously or asynchronously, and that choice applies to every element. They give a per-element reset value. The block sits after combinational logic and registers its results without any buffering or handshake.

Top module: `slice_reg_group`

## Requirements
- R1: Every element uses the same clock, set/reset and clock enable. No element can be controlled on its own.
- R2: With clock enable high and set/reset low, a flip-flop element loads its data input at each active clock edge. It changes at no other time.
- R3: With clock enable low and set/reset low, every element keeps its value, whatever its data input does.
- R4: With synchronous set/reset, a high `sr_i` at an active edge loads each element with its reset value, even when clock enable is low. A latch element takes its reset value while its clock level is high.
- R5: With asynchronous set/reset, a rising `sr_i` forces every element to its reset value at once, with no clock edge needed.
- R6: With asynchronous set/reset, the internal reset is released at the first active edge after `sr_i` falls. Flip-flop elements keep their reset value through that edge and load data again from the next one. Latch elements may go transparent right after it.
- R7: When `INV_CLK` is 0 the active edge is the rising edge of `clk_i`. When `INV_CLK` is 1 it is the falling edge, and the latch-open level is `clk_i` low.
- R8: Elements 0 to 3 are always flip-flops. Elements 4 to 7 are latches when `CFG_KIND` is `STORE_LATCH` and flip-flops when it is `STORE_FLOP`.
- R9: A latch element follows its data input while the effective clock level is high and clock enable is high. It holds while the effective clock level is low or clock enable is low.
- R10: The reset value of element i is bit i of `INIT`, and each bit may be 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared clock; polarity set by `INV_CLK` |
| sr_i | input | 1 | Shared set/reset, active high |
| ce_i | input | 1 | Shared clock enable, active high |
| d_i | input | N_FIXED+N_CFG | One data bit per element |
| q_o | output | N_FIXED+N_CFG | One stored bit per element |

## Verification
The bench builds four copies side by side. Together they cover every combination of clock polarity, set/reset mode and group kind that matters. One copy has a true clock, synchronous reset and all flip-flops. One has an inverted clock, asynchronous reset and a latch group. One has a true clock, asynchronous reset and all flip-flops. One has an inverted clock, synchronous reset and a latch group. Each copy has a different mixed reset pattern.

A sweep drives all 256 data values with interleaved enable-low and reset pulses. This includes resets with enable low and releases with enable low and high. Outputs are checked both between edges and after them. Mid-phase data changes then show latch transparency against flip-flop capture, and falling-edge against rising-edge timing.

// File: rtl/slice_reg_pkg.sv
package slice_reg_pkg;
  typedef enum logic {
    STORE_FLOP  = 1'b0,
    STORE_LATCH = 1'b1
  } store_kind_e;
endpackage

// File: rtl/slice_clk_pol.sv
module slice_clk_pol #(
  parameter bit INV_CLK = 1'b0
) (
  input  logic clk_i,
  output logic eclk_o
);
  if (INV_CLK) begin : g_inv
    assign eclk_o = ~clk_i;
  end else begin : g_true
    assign eclk_o = clk_i;
  end
endmodule

// File: rtl/slice_sr_ctrl.sv
module slice_sr_ctrl #(
  parameter bit SR_ASYNC = 1'b0
) (
  input  logic eclk_i,
  input  logic sr_i,
  output logic sr_eff_o
);
  if (SR_ASYNC) begin : g_async
    logic hold_q;
    // assert at once, release on the next active edge
    always_ff @(posedge eclk_i or posedge sr_i) begin
      if (sr_i) hold_q <= 1'b1;
      else      hold_q <= 1'b0;
    end
    assign sr_eff_o = sr_i | hold_q;

    p_release_r6: assert property (@(posedge eclk_i) disable iff (sr_i)
      hold_q |=> !sr_eff_o);
  end else begin : g_sync
    assign sr_eff_o = sr_i;
  end
endmodule

// File: rtl/slice_ff_elem.sv
module slice_ff_elem #(
  parameter bit SR_ASYNC = 1'b0,
  parameter bit INIT_BIT = 1'b0
) (
  input  logic eclk_i,
  input  logic sr_eff_i,
  input  logic ce_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  if (SR_ASYNC) begin : g_async
    always_ff @(posedge eclk_i or posedge sr_eff_i) begin
      if (sr_eff_i)  q_q <= INIT_BIT;
      else if (ce_i) q_q <= d_i;
    end
  end else begin : g_sync
    always_ff @(posedge eclk_i) begin
      if (sr_eff_i)  q_q <= INIT_BIT;
      else if (ce_i) q_q <= d_i;
    end
  end

  assign q_o = q_q;

  p_capture_r2: assert property (@(posedge eclk_i) disable iff (sr_eff_i)
    ce_i |=> q_o == $past(d_i));
  p_hold_r3: assert property (@(posedge eclk_i) disable iff (sr_eff_i)
    !ce_i |=> $stable(q_o));
  p_reset_val_r4: assert property (@(posedge eclk_i)
    sr_eff_i |=> q_o == INIT_BIT);
endmodule

// File: rtl/slice_lat_elem.sv
module slice_lat_elem #(
  parameter bit SR_ASYNC = 1'b0,
  parameter bit INIT_BIT = 1'b0
) (
  input  logic eclk_i,
  input  logic sr_eff_i,
  input  logic ce_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  if (SR_ASYNC) begin : g_async
    always_latch begin
      if (sr_eff_i)            q_q <= INIT_BIT;
      else if (eclk_i && ce_i) q_q <= d_i;
    end
  end else begin : g_sync
    // synchronous flavour: reset only acts during the open level
    always_latch begin
      if (eclk_i && sr_eff_i)  q_q <= INIT_BIT;
      else if (eclk_i && ce_i) q_q <= d_i;
    end
  end

  assign q_o = q_q;

  p_open_follow_r9: assert property (@(negedge eclk_i) disable iff (sr_eff_i)
    ce_i |-> q_o == d_i);
endmodule

// File: rtl/slice_reg_group.sv
module slice_reg_group
  import slice_reg_pkg::*;
#(
  parameter int                            N_FIXED  = 4,
  parameter int                            N_CFG    = 4,
  parameter bit                            INV_CLK  = 1'b0,
  parameter bit                            SR_ASYNC = 1'b0,
  parameter store_kind_e                   CFG_KIND = STORE_FLOP,
  parameter logic [N_FIXED+N_CFG-1:0]      INIT     = '0
) (
  input  logic                     clk_i,
  input  logic                     sr_i,
  input  logic                     ce_i,
  input  logic [N_FIXED+N_CFG-1:0] d_i,
  output logic [N_FIXED+N_CFG-1:0] q_o
);
  localparam int N = N_FIXED + N_CFG;

  logic eclk;
  logic sr_eff;

  slice_clk_pol #(.INV_CLK(INV_CLK)) u_clk (
    .clk_i (clk_i),
    .eclk_o(eclk)
  );

  slice_sr_ctrl #(.SR_ASYNC(SR_ASYNC)) u_sr (
    .eclk_i  (eclk),
    .sr_i    (sr_i),
    .sr_eff_o(sr_eff)
  );

  for (genvar i = 0; i < N; i++) begin : g_elem
    if (i >= N_FIXED && CFG_KIND == STORE_LATCH) begin : g_lat
      slice_lat_elem #(.SR_ASYNC(SR_ASYNC), .INIT_BIT(INIT[i])) u_e (
        .eclk_i  (eclk),
        .sr_eff_i(sr_eff),
        .ce_i    (ce_i),
        .d_i     (d_i[i]),
        .q_o     (q_o[i])
      );
    end else begin : g_ff
      slice_ff_elem #(.SR_ASYNC(SR_ASYNC), .INIT_BIT(INIT[i])) u_e (
        .eclk_i  (eclk),
        .sr_eff_i(sr_eff),
        .ce_i    (ce_i),
        .d_i     (d_i[i]),
        .q_o     (q_o[i])
      );
    end
  end
endmodule

// File: tb/sim_slice_reg_group.sv
`timescale 1ns/100ps
module sim_slice_reg_group;
  import slice_reg_pkg::*;

  localparam logic [7:0] INIT0 = 8'hA5;
  localparam logic [7:0] INIT1 = 8'h3C;
  localparam logic [7:0] INIT2 = 8'h0F;
  localparam logic [7:0] INIT3 = 8'hC6;

  logic       clk = 1'b0;
  logic       sr  = 1'b1;
  logic       ce  = 1'b0;
  logic [7:0] d   = 8'h00;
  logic [7:0] q0, q1, q2, q3;

  always #2 clk = ~clk;

  // true clk, sync sr, all flops
  slice_reg_group #(.INV_CLK(1'b0), .SR_ASYNC(1'b0), .CFG_KIND(STORE_FLOP),  .INIT(INIT0))
    u0 (.clk_i(clk), .sr_i(sr), .ce_i(ce), .d_i(d), .q_o(q0));
  // inverted clk, async sr, latch group
  slice_reg_group #(.INV_CLK(1'b1), .SR_ASYNC(1'b1), .CFG_KIND(STORE_LATCH), .INIT(INIT1))
    u1 (.clk_i(clk), .sr_i(sr), .ce_i(ce), .d_i(d), .q_o(q1));
  // true clk, async sr, all flops
  slice_reg_group #(.INV_CLK(1'b0), .SR_ASYNC(1'b1), .CFG_KIND(STORE_FLOP),  .INIT(INIT2))
    u2 (.clk_i(clk), .sr_i(sr), .ce_i(ce), .d_i(d), .q_o(q2));
  // inverted clk, sync sr, latch group
  slice_reg_group #(.INV_CLK(1'b1), .SR_ASYNC(1'b0), .CFG_KIND(STORE_LATCH), .INIT(INIT3))
    u3 (.clk_i(clk), .sr_i(sr), .ce_i(ce), .d_i(d), .q_o(q3));

  logic [7:0] init_v [4] = '{INIT0, INIT1, INIT2, INIT3};
  logic [7:0] lag_v  [4] = '{8'h00, 8'h0F, 8'hFF, 8'h00}; // async flop elements
  logic       asy_v  [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
  logic [7:0] exp_v  [4];
  logic       prev_sr = 1'b1;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  function automatic logic [7:0] q_of(int k);
    case (k)
      0: return q0;
      1: return q1;
      2: return q2;
      default: return q3;
    endcase
  endfunction

  task automatic chk(string req, int k, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s u%0d t=%0t act=%h exp=%h", req, k, $time, act, exp);
    end
  endtask

  // one clock period starting at posedge+1
  task automatic step(input logic [7:0] dv, input logic cev, input logic srv);
    d = dv; ce = cev; sr = srv;
    #0.5;
    for (int k = 0; k < 4; k++) begin
      if (srv && asy_v[k]) chk("R5", k, q_of(k), init_v[k]);
      else                 chk("R9", k, q_of(k), exp_v[k]); // no edge yet: all hold
    end
    #3.5;
    for (int k = 0; k < 4; k++) begin
      if (srv)                     exp_v[k] = init_v[k];
      else if (prev_sr && asy_v[k]) begin
        if (cev) exp_v[k] = (init_v[k] & lag_v[k]) | (dv & ~lag_v[k]);
      end else if (cev)            exp_v[k] = dv;
    end
    prev_sr = srv;
    for (int k = 0; k < 4; k++)
      chk(srv ? "R4" : (cev ? "R2" : "R3"), k, q_of(k), exp_v[k]);
  endtask

  // data changes while inverted-clock latches are open
  task automatic open_step(input logic [7:0] d1, input logic [7:0] d2);
    d = d1; ce = 1'b1; sr = 1'b0;
    #1.5 d = d2;
    #0.5;
    chk("R7", 0, q0, exp_v[0]);
    chk("R7", 2, q2, exp_v[2]);
    chk("R9", 1, q1, {d2[7:4], d1[3:0]});
    chk("R8", 3, q3, {d2[7:4], d1[3:0]});
    #2;
    exp_v[0] = d2;
    exp_v[2] = d2;
    exp_v[1] = {d2[7:4], d1[3:0]};
    exp_v[3] = {d2[7:4], d1[3:0]};
    prev_sr = 1'b0;
    for (int k = 0; k < 4; k++) chk("R8", k, q_of(k), exp_v[k]);
  endtask

  initial begin
    #11;
    for (int k = 0; k < 4; k++) begin
      exp_v[k] = init_v[k];
      chk("R10", k, q_of(k), init_v[k]);
    end
    // R1: one shared ce/sr drives every element of every copy
    for (int i = 0; i < 256; i++) begin
      logic [7:0] dv;
      dv = 8'(i * 37 + 11);
      step(dv, (i % 5) != 3, (i % 37) == 36);
    end
    open_step(8'h3C, 8'hC3);
    open_step(8'hFF, 8'h00);
    open_step(8'h00, 8'hFF);
    step(8'h55, 1'b0, 1'b1);
    step(8'hAA, 1'b0, 1'b1);
    step(8'h11, 1'b1, 1'b0);
    step(8'h22, 1'b1, 1'b0);
    step(8'h33, 1'b0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule